// File: doc/BRIEF.md
# Graphic LCD Column-Driver Host Port

This block is the processor-facing side of a 64-column graphic LCD column controller. A host drives an 8-bit data bus, an enable strobe, a read/write line, a register-select line and three chip selects. The block decodes the accesses and holds four pieces of state: the page register, the auto-incrementing column counter, the start-line register and the display-enable flag. It drives a byte-wide synchronous port into a 512-byte display memory and answers status reads.

All inputs are sampled on the system clock. An access takes effect on the first clock edge at which the enable strobe is seen low after being high. A data read is pipelined through an output register, so the host must issue one throwaway read after moving the address. After each accepted access a busy flag holds for a fixed number of clock cycles. During that time every access except a status read is ignored.

Top module: `glcd_host_if`

## Requirements
- R1: An access is honoured only when `cs1_n`=0, `cs2_n`=0 and `cs3`=1. Any other combination leaves every register and the memory untouched. Reset acts whatever the chip selects are.
- R2: `{rs,rw}` selects the access kind: 00 instruction write, 01 status read, 10 data write, 11 data read.
- R3: Instruction bytes: `0011111d` sets the display flag to d (1 = on). `01cccccc` loads the column counter. `10111ppp` loads the page. `11ssssss` loads the start line. Any other byte changes nothing.
- R4: Writes and instructions take effect at the falling edge of `e`, and never while `e` is still high.
- R5: A data read returns the output register while `e` is high. At its falling edge the read moves the addressed byte into that register, so the first read after moving the address returns stale data.
- R6: Every accepted data read or write advances the column by one, wrapping from 63 to 0. The page never changes by itself.
- R7: The status byte carries busy on bit 7, display-off on bit 5 (1 when off) and reset-active on bit 4. All other bits are 0. It needs no throwaway read.
- R8: While `rst_n` is low, the display is off and the start line, page and column are 0. Only status reads are served.
- R9: Each accepted access other than a status read raises busy for BUSY_CYC clock cycles (default 2). Accesses other than status reads are ignored while busy is high.
- R10: `db_oe` is high only while `e`=1, `rw`=1 and the chip is selected.
- R11: The memory address is `{page, column}`. A data write produces a one-cycle `ram_we` carrying the host byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| e | input | 1 | Host enable strobe |
| rw | input | 1 | 1 = read, 0 = write |
| rs | input | 1 | 1 = data, 0 = instruction/status |
| cs1_n | input | 1 | Chip select, active low |
| cs2_n | input | 1 | Chip select, active low |
| cs3 | input | 1 | Chip select, active high |
| db_in | input | 8 | Host write data |
| db_out | output | 8 | Host read data |
| db_oe | output | 1 | Bus drive enable |
| ram_addr | output | 9 | Display memory address {page, column} |
| ram_we | output | 1 | Memory write strobe |
| ram_re | output | 1 | Memory read strobe |
| ram_wdata | output | 8 | Memory write data |
| ram_rdata | input | 8 | Memory read data, one cycle after `ram_re` |
| disp_on | output | 1 | Display enable flag |
| start_line | output | 6 | Top displayed line |

## Verification
The hardest state to reach from the ports is an access whose falling edge lands inside the busy window. With normal host timing this never happens. The stimulus therefore issues a command with no idle gap and follows it with a one-cycle strobe, so the second edge lands while busy is still high. The same short strobe is used for a status read, which shows busy as set. Column wrap under a fixed page is reached by placing the column at 62 and streaming writes and pipelined reads across the wrap.

// File: rtl/glcd_pkg.sv
package glcd_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    ACC_INSTR = 2'b00,
    ACC_STAT  = 2'b01,
    ACC_WDATA = 2'b10,
    ACC_RDATA = 2'b11
  } acc_kind_t;

  typedef struct packed {
    logic       set_disp;
    logic       disp_val;
    logic       set_col;
    logic       set_page;
    logic       set_start;
    logic [5:0] arg;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [DW-1:0] b);
    cmd_t c;
    c     = '0;
    c.arg = b[5:0];
    if (b[7:1] == 7'b0011111) begin
      c.set_disp = 1'b1;
      c.disp_val = b[0];
    end else if (b[7:6] == 2'b01) begin
      c.set_col = 1'b1;
    end else if (b[7:3] == 5'b10111) begin
      c.set_page = 1'b1;
    end else if (b[7:6] == 2'b11) begin
      c.set_start = 1'b1;
    end
    return c;
  endfunction

  function automatic logic [DW-1:0] pack_status(input logic busy, input logic on,
                                                input logic in_rst);
    return {busy, 1'b0, ~on, in_rst, 4'b0000};
  endfunction
endpackage

// File: rtl/glcd_strobe.sv
module glcd_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic e,
  output logic fall
);
  logic e_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) e_q <= 1'b0;
    else        e_q <= e;
  end

  assign fall = e_q & ~e;
endmodule

// File: rtl/glcd_busy.sv
module glcd_busy #(
  parameter int BUSY_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(BUSY_CYC);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/glcd_regs.sv
module glcd_regs
  import glcd_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter int COL_W  = 6,
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_ev,
  input  cmd_t              cmd,
  input  logic              data_ev,
  output logic [PAGE_W-1:0] page,
  output logic [COL_W-1:0]  col,
  output logic [LINE_W-1:0] start_line,
  output logic              disp_on
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page       <= '0;
      col        <= '0;
      start_line <= '0;
      disp_on    <= 1'b0;
    end else begin
      if (cmd_ev) begin
        if (cmd.set_disp)  disp_on    <= cmd.disp_val;
        if (cmd.set_col)   col        <= cmd.arg[COL_W-1:0];
        if (cmd.set_page)  page       <= cmd.arg[PAGE_W-1:0];
        if (cmd.set_start) start_line <= cmd.arg[LINE_W-1:0];
      end
      if (data_ev) col <= col + COL_W'(1);
    end
  end
endmodule

// File: rtl/glcd_host_if.sv
module glcd_host_if
  import glcd_pkg::*;
#(
  parameter int PAGE_W   = 3,
  parameter int COL_W    = 6,
  parameter int LINE_W   = 6,
  parameter int BUSY_CYC = 2,
  localparam int ADDR_W  = PAGE_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e,
  input  logic              rw,
  input  logic              rs,
  input  logic              cs1_n,
  input  logic              cs2_n,
  input  logic              cs3,
  input  logic [DW-1:0]     db_in,
  output logic [DW-1:0]     db_out,
  output logic              db_oe,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic              ram_re,
  output logic [DW-1:0]     ram_wdata,
  input  logic [DW-1:0]     ram_rdata,
  output logic              disp_on,
  output logic [LINE_W-1:0] start_line
);
  // Named internal events, used by the bound checker
  logic              sel;
  logic              fall_ev;
  logic              busy;
  logic              take_ev;
  logic              cmd_ev;
  logic              wr_ev;
  logic              rd_ev;
  logic              data_ev;
  logic [PAGE_W-1:0] page;
  logic [COL_W-1:0]  col;
  logic              rd_pend;
  logic [DW-1:0]     out_reg;
  acc_kind_t         kind;

  assign sel  = ~cs1_n & ~cs2_n & cs3;
  assign kind = acc_kind_t'({rs, rw});

  glcd_strobe u_strobe (
    .clk  (clk),
    .rst_n(rst_n),
    .e    (e),
    .fall (fall_ev)
  );

  assign take_ev = rst_n & fall_ev & sel & ~busy & (kind != ACC_STAT);
  assign cmd_ev  = take_ev & (kind == ACC_INSTR);
  assign wr_ev   = take_ev & (kind == ACC_WDATA);
  assign rd_ev   = take_ev & (kind == ACC_RDATA);
  assign data_ev = wr_ev | rd_ev;

  glcd_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk  (clk),
    .rst_n(rst_n),
    .start(take_ev),
    .busy (busy)
  );

  glcd_regs #(.PAGE_W(PAGE_W), .COL_W(COL_W), .LINE_W(LINE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ev    (cmd_ev),
    .cmd       (decode_cmd(db_in)),
    .data_ev   (data_ev),
    .page      (page),
    .col       (col),
    .start_line(start_line),
    .disp_on   (disp_on)
  );

  assign ram_addr  = {page, col};
  assign ram_we    = wr_ev;
  assign ram_re    = rd_ev;
  assign ram_wdata = db_in;

  // Read pipeline: memory answers one cycle after the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      out_reg <= '0;
    end else begin
      rd_pend <= rd_ev;
      if (rd_pend) out_reg <= ram_rdata;
    end
  end

  assign db_oe  = e & rw & sel;
  assign db_out = rs ? out_reg : pack_status(busy, disp_on, ~rst_n);
endmodule

// File: rtl/glcd_host_if_chk.sv
module glcd_host_if_chk #(
  parameter int PAGE_W = 3,
  parameter int COL_W  = 6,
  parameter int LINE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              e,
  input logic              rw,
  input logic              rs,
  input logic              cs1_n,
  input logic              cs2_n,
  input logic              cs3,
  input logic              db_oe,
  input logic              disp_on,
  input logic [LINE_W-1:0] start_line,
  input logic              fall_ev,
  input logic              busy,
  input logic              take_ev,
  input logic              data_ev,
  input logic [PAGE_W-1:0] page,
  input logic [COL_W-1:0]  col
);
  logic chip_sel;
  assign chip_sel = !cs1_n && !cs2_n && cs3;

  // R10
  bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_oe |-> (e && rw && chip_sel));

  // R1
  desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev && !chip_sel) |=> ($stable(disp_on) && $stable(start_line)
                                && $stable(page) && $stable(col)));

  // R9
  busy_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev |=> busy);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev && busy && !(!rs && rw)) |=> ($stable(disp_on) && $stable(start_line)
                                          && $stable(page) && $stable(col)));

  // R6
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_ev |=> (col == COL_W'($past(col) + 1'b1)));

  // R6
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_ev |=> $stable(page));

  // R8
  rst_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!disp_on && start_line == '0));
endmodule

bind glcd_host_if glcd_host_if_chk #(.PAGE_W(PAGE_W), .COL_W(COL_W), .LINE_W(LINE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .e         (e),
  .rw        (rw),
  .rs        (rs),
  .cs1_n     (cs1_n),
  .cs2_n     (cs2_n),
  .cs3       (cs3),
  .db_oe     (db_oe),
  .disp_on   (disp_on),
  .start_line(start_line),
  .fall_ev   (fall_ev),
  .busy      (busy),
  .take_ev   (take_ev),
  .data_ev   (data_ev),
  .page      (page),
  .col       (col)
);

// File: tb/glcd_host_if_test.sv
module glcd_host_if_test;
  localparam int BUSY_CYC = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       e = 1'b0, rw = 1'b0, rs = 1'b0;
  logic       cs1_n = 1'b0, cs2_n = 1'b0, cs3 = 1'b1;
  logic [7:0] db_in = 8'h00;
  logic [7:0] db_out, ram_wdata, ram_rdata;
  logic       db_oe, ram_we, ram_re, disp_on;
  logic [8:0] ram_addr;
  logic [5:0] start_line;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  glcd_host_if uut (
    .clk(clk), .rst_n(rst_n), .e(e), .rw(rw), .rs(rs),
    .cs1_n(cs1_n), .cs2_n(cs2_n), .cs3(cs3),
    .db_in(db_in), .db_out(db_out), .db_oe(db_oe),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .disp_on(disp_on), .start_line(start_line)
  );

  // Display memory seen by the block
  logic [7:0] mem [512];
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_on, m_start, m_page, m_col, m_busy, m_out, m_paddr;
  int m_mem [512];
  bit m_pend, m_eq;

  always @(posedge clk) begin
    bit selv, take;
    int kind, d, st;
    selv = !cs1_n && !cs2_n && cs3;
    kind = {rs, rw};
    d    = db_in;
    if (!rst_n) begin
      m_on = 0; m_start = 0; m_page = 0; m_col = 0;
      m_busy = 0; m_out = 0; m_pend = 0; m_eq = 0;
    end else begin
      if (m_pend) begin m_out = m_mem[m_paddr]; m_pend = 0; end
      take = m_eq && !e && selv && m_busy == 0 && kind != 1;
      if (m_busy > 0) m_busy--;
      if (take) begin
        m_busy = BUSY_CYC;
        if (kind == 0) begin
          if (d == 'h3E || d == 'h3F)        m_on    = d - 'h3E;
          else if (d >= 'h40 && d < 'h80)    m_col   = d - 'h40;
          else if (d >= 'hB8 && d <= 'hBF)   m_page  = d - 'hB8;
          else if (d >= 'hC0)                m_start = d - 'hC0;
        end else if (kind == 2) begin
          m_mem[m_page * 64 + m_col] = d;
          m_col = (m_col + 1) % 64;
        end else begin
          m_paddr = m_page * 64 + m_col;
          m_pend  = 1;
          m_col   = (m_col + 1) % 64;
        end
      end
      m_eq = e;
    end
    #3;
    if (!done) begin
      check("R3 disp_on", disp_on, m_on);
      check("R3 start_line", start_line, m_start);
      check("R10 db_oe", db_oe, e && rw && (!cs1_n && !cs2_n && cs3));
      if (db_oe) begin
        st = ((m_busy != 0) << 7) | ((m_on == 0) << 5) | ((!rst_n) << 4);
        if (rs) check("R5 read data", db_out, m_out);
        else    check("R7 status", db_out, st);
      end
    end
  end

  task automatic bus(input bit r_s, input bit r_w, input logic [7:0] d,
                     input int hi, input int gap, output logic [7:0] q);
    @(negedge clk);
    rs = r_s; rw = r_w; db_in = d; e = 1'b1;
    repeat (hi) @(negedge clk);
    q = db_out;
    e = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] d);
    logic [7:0] q;
    bus(1'b0, 1'b0, d, 2, 3, q);
  endtask

  task automatic wr(input logic [7:0] d);
    logic [7:0] q;
    bus(1'b1, 1'b0, d, 2, 3, q);
  endtask

  task automatic rd(output logic [7:0] q);
    bus(1'b1, 1'b1, 8'h00, 2, 3, q);
  endtask

  task automatic st(output logic [7:0] q);
    bus(1'b0, 1'b1, 8'h00, 2, 3, q);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    logic [7:0] q;
    for (int i = 0; i < 512; i++) begin mem[i] = 8'h00; m_mem[i] = 0; end
    repeat (3) @(negedge clk);
    check("R8 reset disp_on", disp_on, 1'b0);
    check("R8 reset start", start_line, 6'd0);
    st(q); check("R8 R7 status in reset", q, 8'h30);
    cmd(8'h3F); check("R8 cmd ignored in reset", disp_on, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    st(q); check("R7 status off", q, 8'h20);

    // R4: no effect while E high, effect after fall
    @(negedge clk); rs = 0; rw = 0; db_in = 8'h3F; e = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 held while E high", disp_on, 1'b0);
    e = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 taken after fall", disp_on, 1'b1);
    repeat (2) @(negedge clk);
    st(q); check("R7 status on", q, 8'h00);

    // R9: busy visible to a status read right after a command
    bus(1'b0, 1'b0, 8'hC5, 2, 0, q);
    bus(1'b0, 1'b1, 8'h00, 1, 3, q);
    check("R9 busy in status", q, 8'h80);
    check("R3 start line 5", start_line, 6'd5);

    // R2: data write of an on/off-looking byte is not a command
    cmd(8'hBC); cmd(8'h40); wr(8'h3E);
    check("R2 data write not instruction", disp_on, 1'b1);
    // R3: unknown opcode changes nothing
    cmd(8'h00);
    check("R3 unknown opcode", {disp_on, start_line}, {1'b1, 6'd5});

    // R6: writes across column wrap, page held
    cmd(8'hBB); cmd(8'h7E);
    wr(8'hA1); wr(8'hB2); wr(8'hC3);
    cmd(8'h7E);
    rd(q);
    rd(q); check("R5 first real read", q, 8'hA1);
    rd(q); check("R6 col 63", q, 8'hB2);
    rd(q); check("R6 wrap to col 0 same page", q, 8'hC3);
    cmd(8'hBC); cmd(8'h40);
    rd(q);
    rd(q); check("R11 page 4 col 0", q, 8'h3E);

    // R1: deselected command ignored
    cs3 = 1'b0; cmd(8'h3E); cs3 = 1'b1;
    check("R1 deselect cs3", disp_on, 1'b1);
    cs1_n = 1'b1; cmd(8'hC0); cs1_n = 1'b0;
    check("R1 deselect cs1_n", start_line, 6'd5);

    // R9: command landing in busy window is dropped
    bus(1'b0, 1'b0, 8'h3E, 2, 0, q);
    bus(1'b0, 1'b0, 8'h3F, 1, 3, q);
    check("R9 busy drops command", disp_on, 1'b0);
    st(q); check("R7 status after drop", q, 8'h20);

    // R8: reset in operation
    cmd(8'h3F); cmd(8'hC9);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 mid reset off", disp_on, 1'b0);
    check("R8 mid reset start", start_line, 6'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    cmd(8'hBB); rd(q); rd(q);
    check("R8 column cleared by reset", q, 8'hC3);

    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    #400000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule